// File: doc/BRIEF.md
# Two-Digit Decimal Seven-Segment Driver

This block takes a 4-bit binary value and shows it in decimal on a bank of four common-anode seven-segment displays. Values from zero to nine use only the units display. Values from ten to fifteen also light a tens display, which always shows the glyph "1". The units display then shows the value minus ten.

All displays share the seven segment lines, so the block time-multiplexes its two active digits. A free-running refresh counter alternates between the units phase and the tens phase. Each phase lasts `2^REFRESH_BITS` clock cycles, and the units phase comes first after reset. The segment lines are active low. An anode enable is active high. Of the four anode enables, only the two lowest are ever driven. For a single-digit value the tens display stays dark, so no leading zero is shown.

Top module: `bcd_seg_mux`

## Requirements
- R1: During the units phase, `seg_n` carries the inverted decimal glyph of the units digit. Bit 0 is segment a, up to bit 6 for segment g, and a segment is lit when its bit is 0. Active-high glyphs: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07 (a, b, c), 8=7F (all), 9=6F.
- R2: An input of 0 lights every segment except g, so `seg_n` = 7'h40 in the units phase.
- R3: An input of 1 lights only segments b and c, so `seg_n` = 7'h79 in the units phase.
- R4: For inputs 10 to 15, the tens phase drives `anode` = 4'b0010 with `seg_n` = 7'h79. The units phase shows the glyph of the value minus ten.
- R5: For inputs 0 to 9, the tens phase drives `anode` = 4'b0000 with `seg_n` = 7'h7F, so the tens display stays blank.
- R6: `anode[3:2]` is always 0, and at most one anode bit is high.
- R7: After reset the units phase (`anode` = 4'b0001) lasts exactly 2^REFRESH_BITS cycles. It is followed by a tens phase of the same length, and the two phases keep alternating.
- R8: A synchronous active-high `rst` clears the refresh counter, so the units phase is shown during reset and starts afresh after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| value | input | 4 | Binary value to display |
| seg_n | output | 7 | Segments a (bit 0) to g (bit 6), active low |
| anode | output | 4 | Display enables, active high; bit 0 is units, bit 1 is tens |

## Verification
The assertions assume that `value` only changes between clock edges and is always a defined 4-bit code. They also assume that `rst` is held for at least one edge before checking begins. The bench changes `value` only at falling edges. It walks all sixteen codes through a full units and tens cycle each, and it applies reset once from inside a tens phase. Because of this, every property sees each glyph and both phase kinds under stable inputs.

// File: rtl/bcd_seg_mux.sv
module bcd_seg_mux #(
  parameter int REFRESH_BITS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] value,
  output logic [6:0] seg_n,
  output logic [3:0] anode
);
  localparam int CW = REFRESH_BITS + 1;
  localparam logic [6:0] BLANK_N = 7'h7F;

  logic [CW-1:0] refresh;
  logic          tens_sel;
  logic          two_digit;
  logic [3:0]    units;

  function automatic logic [6:0] glyph(input logic [3:0] d);
    case (d)
      4'd0:    glyph = 7'h3F;
      4'd1:    glyph = 7'h06;
      4'd2:    glyph = 7'h5B;
      4'd3:    glyph = 7'h4F;
      4'd4:    glyph = 7'h66;
      4'd5:    glyph = 7'h6D;
      4'd6:    glyph = 7'h7D;
      4'd7:    glyph = 7'h07;
      4'd8:    glyph = 7'h7F;
      4'd9:    glyph = 7'h6F;
      default: glyph = 7'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) refresh <= '0;
    else     refresh <= refresh + 1'b1;
  end

  assign tens_sel  = refresh[CW-1];
  assign two_digit = value > 4'd9;
  assign units     = two_digit ? value - 4'd10 : value;

  assign anode = tens_sel ? {2'b00, two_digit, 1'b0} : 4'b0001;
  assign seg_n = tens_sel ? (two_digit ? ~glyph(4'd1) : BLANK_N) : ~glyph(units);

  // R1: the units display never goes dark
  p_units_lit_r1: assert property (@(posedge clk) disable iff (rst)
    anode[0] |-> seg_n != BLANK_N);

  p_tens_one_r4: assert property (@(posedge clk) disable iff (rst)
    anode[1] |-> (seg_n == 7'h79 && value > 4'd9));

  p_blank_r5: assert property (@(posedge clk) disable iff (rst)
    (anode == 4'b0000) |-> (seg_n == BLANK_N && value < 4'd10));

  p_upper_off_r6: assert property (@(posedge clk) disable iff (rst)
    anode[3:2] == 2'b00);

  p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(anode) <= 1);
endmodule

// File: tb/bcd_seg_mux_bench.sv
module bcd_seg_mux_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RB = 2;
  localparam int PHASE = 1 << RB;

  // {value, units seg_n, tens anode, tens seg_n}
  localparam logic [21:0] VEC [16] = '{
    {4'd0,  7'h40, 4'h0, 7'h7F}, {4'd1,  7'h79, 4'h0, 7'h7F},
    {4'd2,  7'h24, 4'h0, 7'h7F}, {4'd3,  7'h30, 4'h0, 7'h7F},
    {4'd4,  7'h19, 4'h0, 7'h7F}, {4'd5,  7'h12, 4'h0, 7'h7F},
    {4'd6,  7'h02, 4'h0, 7'h7F}, {4'd7,  7'h78, 4'h0, 7'h7F},
    {4'd8,  7'h00, 4'h0, 7'h7F}, {4'd9,  7'h10, 4'h0, 7'h7F},
    {4'd10, 7'h40, 4'h2, 7'h79}, {4'd11, 7'h79, 4'h2, 7'h79},
    {4'd12, 7'h24, 4'h2, 7'h79}, {4'd13, 7'h30, 4'h2, 7'h79},
    {4'd14, 7'h19, 4'h2, 7'h79}, {4'd15, 7'h12, 4'h2, 7'h79}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] value = 4'd0;
  logic [6:0] seg_n;
  logic [3:0] anode;
  int         k = 0;
  int         checks = 0;
  int         errors = 0;

  bcd_seg_mux #(.REFRESH_BITS(RB)) u_bcd_seg_mux (
    .clk(clk), .rst(rst), .value(value), .seg_n(seg_n), .anode(anode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) k <= 0;
    else     k <= k + 1;
  end

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s anode/seg_n actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R8", {anode, seg_n}, {4'b0001, 7'h40});
    @(negedge clk);
    rst = 1'b0;

    for (int v = 0; v < 16; v++) begin
      logic [21:0] e = VEC[v];
      value = e[21:18];
      for (int c = 0; c < 2 * PHASE; c++) begin
        #1;
        if ((k % (2 * PHASE)) < PHASE)
          check(v == 0 ? "R2" : v == 1 ? "R3" : v >= 10 ? "R4" : "R1",
                {anode, seg_n}, {4'b0001, e[17:11]});
        else
          check(v >= 10 ? "R4" : "R5", {anode, seg_n}, {e[10:7], e[6:0]});
        @(negedge clk);
      end
    end

    // R8: reset applied in the middle of a tens phase
    value = 4'd12;
    while ((k % (2 * PHASE)) != PHASE + 1) @(negedge clk);
    #1 check("R4", {anode, seg_n}, {4'b0010, 7'h79});
    rst = 1'b1;
    @(negedge clk);
    #1 check("R8", {anode, seg_n}, {4'b0001, 7'h24});
    rst = 1'b0;

    // R7 and R6: phase lengths counted from the release of reset
    for (int j = 0; j < 3 * PHASE; j++) begin
      @(negedge clk);
      #1;
      check("R7", {7'd0, anode}, {7'd0, (((j + 1) % (2 * PHASE)) < PHASE) ? 4'b0001 : 4'b0010});
      check("R6", {9'd0, anode[3:2]}, 11'd0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule